// File: doc/BRIEF.md
# Packed Unsigned 64-bit to Half-Precision Converter

This block narrows a vector of unsigned 64-bit integers into IEEE half-precision (FP16) values, one result per 64-bit lane. The vector length is 128, 256 or 512 bits, which gives 2, 4 or 8 lanes. The packed results sit at the bottom of a 512-bit destination. Every destination bit above the packed results is cleared.

Each lane can be gated by a write mask. A gated-off lane either keeps its old destination half-word (merge) or is cleared (zeroing). A memory source can be broadcast, so that every lane converts quadword 0. The rounding mode is taken from an embedded field only for a 512-bit register source with the broadcast/rounding bit set; in every other case it is taken from the control-register field. Overflow and inexact flags are collected over the active lanes. An exception request is raised when an overflow occurs and the overflow mask bit is clear. A nonzero register-specifier field is reported as an undefined operation, and no result is written.

The block is used as one stage of a vector execution pipe: one operation is accepted per cycle, and its result is registered.

Top module: `u64h_pack_cvt`

## Requirements
- R1: `vl_sel` 0, 1 and 2 select 2, 4 and 8 lanes. Lane j's result occupies `dst[16*j+15:16*j]`.
- R2: A lane converts its unsigned quadword to FP16, with sign 0, a 5-bit exponent biased by 15 and a 10-bit fraction. Zero gives 16'h0000. Rounding codes are 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero.
- R3: A rounded value above 65504 overflows. The result is 16'h7C00 for codes 00 and 10, and 16'h7BFF for codes 01 and 11.
- R4: The rounding code is `rc_embed` only when `src_mem`=0, `vl_sel`=2 and `bcast`=1. Otherwise it is `rc_ctrl`.
- R5: When `src_mem`=1 and `bcast`=1, every lane converts `src[63:0]`. Otherwise lane j converts `src[64*j+63:64*j]`.
- R6: A lane is active when `mask_en`=0 or when its `lane_mask` bit is 1. An inactive lane within the length gives 0 if `zeroing`=1, and otherwise keeps its `old_dst` half-word.
- R7: All `dst` bits from 16 times the lane count up to bit 511 are zero after a valid operation.
- R8: `flag_ovf` is the OR of overflow over the active lanes. `flag_inx` is the OR over the active lanes of "a discarded bit below the 11-bit significand is nonzero, or the lane overflowed". Inactive lanes contribute no flags.
- R9: `exc_req` is 1 exactly when `flag_ovf` is 1 and `ovf_mask` is 0.
- R10: When `spec_field` is nonzero, `undef_op` is 1, `dst` equals `old_dst`, and all flags and `exc_req` are 0.
- R11: Outputs appear one cycle after `in_valid`. `out_valid` follows `in_valid` with one cycle of delay. The flags are 0 whenever `out_valid` is 0. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| src | input | 512 | Packed unsigned quadword source |
| old_dst | input | 512 | Previous destination value |
| lane_mask | input | 8 | Per-lane write mask |
| mask_en | input | 1 | Apply the write mask |
| zeroing | input | 1 | 1 = zero inactive lanes, 0 = merge |
| vl_sel | input | 2 | Vector length: 0=128, 1=256, 2=512 |
| src_mem | input | 1 | Source comes from memory |
| bcast | input | 1 | Broadcast / embedded-rounding control |
| rc_embed | input | 2 | Embedded rounding code |
| rc_ctrl | input | 2 | Control-register rounding code |
| ovf_mask | input | 1 | Overflow exception mask |
| spec_field | input | 4 | Register-specifier field, must be zero |
| out_valid | output | 1 | Result valid |
| dst | output | 512 | Packed FP16 result, zero-extended |
| flag_ovf | output | 1 | Overflow flag |
| flag_inx | output | 1 | Precision (inexact) flag |
| exc_req | output | 1 | Unmasked overflow exception request |
| undef_op | output | 1 | Undefined-operation indication |

## Verification
The hardest situations to reach are at the rounding boundaries. One is an input that stays at 65504 under one mode but rounds past it under another. The other is a tie on an even significand, where nearest-even must not increment. The stimulus places hand-picked quadwords such as 2049, 2051, 65519 and 65520 in the lanes and replays them under each rounding code. It also puts an overflowing value in a masked-off lane, so that the flags must stay clear even though the converter sees a huge input.

// File: rtl/u64h_pkg.sv
package u64h_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_DOWN = 2'd1,
        RM_UP   = 2'd2,
        RM_ZERO = 2'd3
    } rmode_e;

    typedef enum logic [1:0] {
        VLEN_128 = 2'd0,
        VLEN_256 = 2'd1,
        VLEN_512 = 2'd2,
        VLEN_RSV = 2'd3
    } vlen_e;

    typedef struct packed {
        logic [15:0] h;
        logic        ovf;
        logic        inx;
    } cvt_res_t;

    localparam logic [15:0] H_PINF = 16'h7C00;
    localparam logic [15:0] H_MAXN = 16'h7BFF;

    function automatic cvt_res_t u64_to_h(input logic [63:0] x, input rmode_e rm);
        cvt_res_t   r;
        int         p;
        int         e;
        int         sh;
        logic [11:0] sig;
        logic       g;
        logic       s;
        logic       inc;
        r   = '0;
        p   = 0;
        sig = '0;
        g   = 1'b0;
        s   = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (x[i]) p = i;
        end
        if (x != 64'd0) begin
            if (p <= 10) begin
                sig = 12'(x << (10 - p));
            end else begin
                sh  = p - 10;
                sig = 12'(x >> sh);
                g   = x[sh-1];
                s   = |(x & ((64'd1 << (sh - 1)) - 64'd1));
            end
            e = p;
            unique case (rm)
                RM_NEAR: inc = g & (s | sig[0]);
                RM_UP:   inc = g | s;
                default: inc = 1'b0;
            endcase
            sig = sig + 12'(inc);
            if (sig[11]) begin
                sig = sig >> 1;
                e   = e + 1;
            end
            if (e > 15) begin
                r.ovf = 1'b1;
                r.h   = (rm == RM_NEAR || rm == RM_UP) ? H_PINF : H_MAXN;
            end else begin
                r.h = {1'b0, 5'(e + 15), sig[9:0]};
            end
            r.inx = g | s | r.ovf;
        end
        return r;
    endfunction

endpackage

// File: rtl/u64h_ctrl.sv
module u64h_ctrl
    import u64h_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [1:0]       vl_sel,
    input  logic             src_mem,
    input  logic             bcast,
    input  logic [1:0]       rc_embed,
    input  logic [1:0]       rc_ctrl,
    input  logic             mask_en,
    input  logic [LANES-1:0] lane_mask,
    output rmode_e           rm,
    output logic             use_q0,
    output logic [LANES-1:0] in_len,
    output logic [LANES-1:0] active
);
    vlen_e vl;
    int    nl;

    always_comb begin
        vl = vlen_e'(vl_sel);
        unique case (vl)
            VLEN_128: nl = 2;
            VLEN_256: nl = 4;
            default:  nl = 8;
        endcase
        rm = (!src_mem && vl == VLEN_512 && bcast) ? rmode_e'(rc_embed)
                                                   : rmode_e'(rc_ctrl);
        use_q0 = src_mem & bcast;
        for (int j = 0; j < LANES; j++) begin
            in_len[j] = (j < nl);
            active[j] = in_len[j] & (~mask_en | lane_mask[j]);
        end
    end
endmodule

// File: rtl/u64h_lane.sv
module u64h_lane
    import u64h_pkg::*;
(
    input  logic [63:0] q,
    input  rmode_e      rm,
    input  logic        active,
    output logic [15:0] h,
    output logic        ovf,
    output logic        inx
);
    cvt_res_t res;

    always_comb begin
        res = u64_to_h(q, rm);
        h   = res.h;
        ovf = active & res.ovf;
        inx = active & res.inx;
    end
endmodule

// File: rtl/u64h_pack_cvt.sv
module u64h_pack_cvt
    import u64h_pkg::*;
#(
    parameter int LANES = 8,
    parameter int QW    = 64,
    parameter int HW    = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [LANES*QW-1:0]    src,
    input  logic [LANES*QW-1:0]    old_dst,
    input  logic [LANES-1:0]       lane_mask,
    input  logic                   mask_en,
    input  logic                   zeroing,
    input  logic [1:0]             vl_sel,
    input  logic                   src_mem,
    input  logic                   bcast,
    input  logic [1:0]             rc_embed,
    input  logic [1:0]             rc_ctrl,
    input  logic                   ovf_mask,
    input  logic [3:0]             spec_field,
    output logic                   out_valid,
    output logic [LANES*QW-1:0]    dst,
    output logic                   flag_ovf,
    output logic                   flag_inx,
    output logic                   exc_req,
    output logic                   undef_op
);
    localparam int SRCW = LANES * QW;
    localparam int RESW = LANES * HW;

    rmode_e           rm;
    logic             use_q0;
    logic [LANES-1:0] in_len;
    logic [LANES-1:0] active;
    logic [LANES-1:0] l_ovf;
    logic [LANES-1:0] l_inx;
    logic [RESW-1:0]  packed_h;

    u64h_ctrl #(.LANES(LANES)) i_ctrl (
        .vl_sel    (vl_sel),
        .src_mem   (src_mem),
        .bcast     (bcast),
        .rc_embed  (rc_embed),
        .rc_ctrl   (rc_ctrl),
        .mask_en   (mask_en),
        .lane_mask (lane_mask),
        .rm        (rm),
        .use_q0    (use_q0),
        .in_len    (in_len),
        .active    (active)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [QW-1:0] q;
        logic [HW-1:0] h;
        assign q = use_q0 ? src[QW-1:0] : src[j*QW +: QW];
        u64h_lane i_lane (
            .q      (q),
            .rm     (rm),
            .active (active[j]),
            .h      (h),
            .ovf    (l_ovf[j]),
            .inx    (l_inx[j])
        );
        always_comb begin
            if (active[j])
                packed_h[j*HW +: HW] = h;
            else if (in_len[j] && !zeroing)
                packed_h[j*HW +: HW] = old_dst[j*HW +: HW];
            else
                packed_h[j*HW +: HW] = '0;
        end
    end

    logic bad_spec;
    logic any_ovf;
    logic any_inx;
    assign bad_spec = (spec_field != 4'd0);
    assign any_ovf  = |l_ovf;
    assign any_inx  = |l_inx;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dst       <= '0;
            flag_ovf  <= 1'b0;
            flag_inx  <= 1'b0;
            exc_req   <= 1'b0;
            undef_op  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            flag_ovf  <= in_valid & ~bad_spec & any_ovf;
            flag_inx  <= in_valid & ~bad_spec & any_inx;
            exc_req   <= in_valid & ~bad_spec & any_ovf & ~ovf_mask;
            undef_op  <= in_valid & bad_spec;
            if (in_valid)
                dst <= bad_spec ? old_dst : {{(SRCW-RESW){1'b0}}, packed_h};
        end
    end

    a_r9_exc_needs_flags: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> (flag_ovf && flag_inx));

    a_r10_undef_quiet: assert property (@(posedge clk) disable iff (rst)
        undef_op |-> (!flag_ovf && !flag_inx && !exc_req));

    a_r11_valid_delay: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid));

    a_r11_idle_flags: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!flag_ovf && !flag_inx && !exc_req && !undef_op));

    a_r7_upper_clear: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !undef_op) |-> (dst[SRCW-1:RESW] == '0));

    a_r1_narrow_clear: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !bad_spec && vl_sel == 2'd0) |=> (dst[SRCW-1:2*HW] == '0));

endmodule

// File: tb/test_u64h_pack_cvt.sv
module test_u64h_pack_cvt;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [511:0] src = '0;
    logic [511:0] old_dst = '0;
    logic [7:0]   lane_mask = '0;
    logic         mask_en = 1'b0;
    logic         zeroing = 1'b0;
    logic [1:0]   vl_sel = 2'd2;
    logic         src_mem = 1'b0;
    logic         bcast = 1'b0;
    logic [1:0]   rc_embed = 2'd0;
    logic [1:0]   rc_ctrl = 2'd0;
    logic         ovf_mask = 1'b1;
    logic [3:0]   spec_field = 4'd0;
    logic         out_valid;
    logic [511:0] dst;
    logic         flag_ovf, flag_inx, exc_req, undef_op;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    u64h_pack_cvt i_u64h_pack_cvt (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .old_dst(old_dst),
        .lane_mask(lane_mask), .mask_en(mask_en), .zeroing(zeroing), .vl_sel(vl_sel),
        .src_mem(src_mem), .bcast(bcast), .rc_embed(rc_embed), .rc_ctrl(rc_ctrl),
        .ovf_mask(ovf_mask), .spec_field(spec_field), .out_valid(out_valid), .dst(dst),
        .flag_ovf(flag_ovf), .flag_inx(flag_inx), .exc_req(exc_req), .undef_op(undef_op)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fire();
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic set_q(input int j, input logic [63:0] v);
        src[j*64 +: 64] = v;
    endtask

    task automatic load_basic();
        set_q(0, 64'd0);     set_q(1, 64'd1);    set_q(2, 64'd3);     set_q(3, 64'd1024);
        set_q(4, 64'd2049);  set_q(5, 64'd2051); set_q(6, 64'd65504); set_q(7, 64'd65519);
    endtask

    task automatic t_reset();
        chk("R11 reset valid", {127'b0, out_valid}, 128'd0);
        chk("R11 reset dst", dst[127:0], 128'd0);
        chk("R11 reset flags", {124'b0, flag_ovf, flag_inx, exc_req, undef_op}, 128'd0);
    endtask

    task automatic t_basic();
        load_basic(); vl_sel = 2'd2; rc_ctrl = 2'd0; mask_en = 0; src_mem = 0; bcast = 0;
        fire();
        chk("R2 R1 nearest lanes", dst[127:0],
            {16'h7BFF, 16'h7BFF, 16'h6802, 16'h6800, 16'h6400, 16'h4200, 16'h3C00, 16'h0000});
        chk("R8 inexact no ovf", {126'b0, flag_ovf, flag_inx}, 128'd1);
        chk("R7 upper clear 512", {127'b0, |dst[511:128]}, 128'd0);
        chk("R11 valid", {127'b0, out_valid}, 128'd1);
        @(negedge clk);
        chk("R11 valid drops", {125'b0, out_valid, flag_inx, flag_ovf}, 128'd0);
        rc_ctrl = 2'd3;
        fire();
        chk("R2 toward zero lanes", dst[127:0],
            {16'h7BFF, 16'h7BFF, 16'h6801, 16'h6800, 16'h6400, 16'h4200, 16'h3C00, 16'h0000});
        rc_ctrl = 2'd2; ovf_mask = 1;
        fire();
        chk("R2 R3 toward plus lanes", dst[127:0],
            {16'h7C00, 16'h7BFF, 16'h6802, 16'h6801, 16'h6400, 16'h4200, 16'h3C00, 16'h0000});
        chk("R9 masked ovf no exc", {125'b0, flag_ovf, flag_inx, exc_req}, 128'd6);
        rc_ctrl = 2'd1;
        fire();
        chk("R2 toward minus lane7", {112'b0, dst[127:112]}, 128'h7BFF);
        chk("R8 no ovf toward minus", {127'b0, flag_ovf}, 128'd0);
    endtask

    task automatic t_round_sel();
        for (int j = 0; j < 8; j++) set_q(j, 64'd2051);
        rc_ctrl = 2'd0; rc_embed = 2'd3; src_mem = 0; bcast = 1; vl_sel = 2'd2;
        fire();
        chk("R4 embedded used", dst[127:0], {8{16'h6801}});
        vl_sel = 2'd1;
        fire();
        chk("R4 ctrl used at 256", dst[127:0], {64'd0, {4{16'h6802}}});
        vl_sel = 2'd2; bcast = 0;
        fire();
        chk("R4 ctrl used no bcast", dst[127:0], {8{16'h6802}});
        bcast = 0;
    endtask

    task automatic t_overflow();
        src = '0; set_q(0, 64'd1 << 40); set_q(1, 64'd1); vl_sel = 2'd0; ovf_mask = 0;
        rc_ctrl = 2'd0;
        fire();
        chk("R3 nearest inf", dst[127:0], {96'd0, 16'h3C00, 16'h7C00});
        chk("R9 exc raised", {125'b0, flag_ovf, flag_inx, exc_req}, 128'd7);
        rc_ctrl = 2'd3;
        fire();
        chk("R3 zero maxnorm", {112'b0, dst[15:0]}, 128'h7BFF);
        rc_ctrl = 2'd1;
        fire();
        chk("R3 minus maxnorm", {112'b0, dst[15:0]}, 128'h7BFF);
        rc_ctrl = 2'd2;
        fire();
        chk("R3 plus inf", {112'b0, dst[15:0]}, 128'h7C00);
        src = '0; set_q(0, 64'd65520); rc_ctrl = 2'd0;
        fire();
        chk("R3 tie rounds over", {109'b0, dst[15:0], flag_ovf, flag_inx, exc_req}, {109'b0, 16'h7C00, 3'b111});
        ovf_mask = 1;
    endtask

    task automatic t_bcast();
        src = '0; set_q(0, 64'd3); for (int j = 1; j < 8; j++) set_q(j, 64'd1024);
        vl_sel = 2'd1; src_mem = 1; bcast = 1; rc_ctrl = 2'd0;
        fire();
        chk("R5 broadcast q0", dst[127:0], {64'd0, {4{16'h4200}}});
        bcast = 0;
        fire();
        chk("R5 no broadcast", dst[127:0], {64'd0, {3{16'h6400}}, 16'h4200});
        src_mem = 0;
    endtask

    task automatic t_mask();
        src = '0; set_q(0, 64'd1); set_q(1, 64'd1 << 40);
        old_dst = {512{1'b1}}; vl_sel = 2'd0; mask_en = 1; lane_mask = 8'b01; zeroing = 0;
        rc_ctrl = 2'd0; ovf_mask = 0;
        fire();
        chk("R6 merge", dst[127:0], {96'd0, 16'hFFFF, 16'h3C00});
        chk("R7 upper clear 128", {127'b0, |dst[511:32]}, 128'd0);
        chk("R8 masked lane no flags", {125'b0, flag_ovf, flag_inx, exc_req}, 128'd0);
        zeroing = 1;
        fire();
        chk("R6 zeroing", dst[127:0], {96'd0, 16'h0000, 16'h3C00});
        lane_mask = 8'hFE;
        fire();
        chk("R6 R1 mask above length", dst[127:0], {96'd0, 16'h7C00, 16'h0000});
        chk("R8 active lane ovf", {126'b0, flag_ovf, flag_inx}, 128'd3);
        mask_en = 0;
        fire();
        chk("R6 no mask all lanes", dst[127:0], {96'd0, 16'h7C00, 16'h3C00});
        zeroing = 0; ovf_mask = 1; old_dst = '0;
    endtask

    task automatic t_undef();
        old_dst = '0;
        for (int j = 0; j < 16; j++) old_dst[j*32 +: 32] = 32'hA5000000 + 32'(j);
        src = '0; set_q(0, 64'd1 << 40); vl_sel = 2'd2; ovf_mask = 0; spec_field = 4'd2;
        fire();
        chk("R10 undef flag", {124'b0, undef_op, flag_ovf, flag_inx, exc_req}, 128'd8);
        for (int k = 0; k < 4; k++)
            chk("R10 dst unchanged", dst[k*128 +: 128], old_dst[k*128 +: 128]);
        spec_field = 4'd0; ovf_mask = 1;
        fire();
        chk("R10 clears after", {127'b0, undef_op}, 128'd0);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_round_sel();
        t_overflow();
        t_bcast();
        t_mask();
        t_undef();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule